// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator-based processor. Every two-operand operation combines the accumulator with a second byte. That byte is picked from an immediate value, a general register or a memory byte. The operation returns an 8-bit result and updates a five-bit status set: sign, zero, auxiliary (half) carry, even parity and carry. Increment and decrement act on the selected operand itself rather than on the accumulator. A separate 16-bit path adds a register pair to the HL pair.

The decoder outside the block presents an operation code, a source select and the operand values, then raises `wr_en` for one cycle. The combinational core settles within that cycle. On the clock edge the result, the 16-bit pair sum, the flags and a set of one-cycle write strobes are registered. The strobes tell the register file which destination to update: the accumulator, the operand location or the HL pair. The flags are held inside the block and fed back as the carry input for the add-with-carry and subtract-with-borrow operations.

Top module: `acc_alu`

## Requirements
- R1: `src_i` picks the second operand: 0 gives `imm_i`, 1 gives `reg_i`, 2 or 3 gives `mem_i`.
- R2: Operation codes 0 ADD, 1 ADC, 2 SUB and 3 SBB produce acc+b, acc+b+CY, acc-b and acc-b-CY modulo 256. CY is the registered carry flag. The result appears on `result_o` one cycle after `wr_en`, with `acc_wr_o` high for that cycle.
- R3: Codes 4 AND, 5 XOR and 6 OR produce the bitwise result with `acc_wr_o` high, and they clear both CY and AC.
- R4: Code 7 CMP sets all five flags exactly as SUB would and shows the difference on `result_o`, but `acc_wr_o` stays low.
- R5: AC is the carry out of bit 3 of the adder. Subtraction adds the one's complement of b, with a carry-in of 1 for SUB/CMP and of not-CY for SBB. Increment adds 1 and decrement adds 0xFF.
- R6: The zero flag is set when the 8-bit result is 0, and the sign flag equals bit 7 of the result.
- R7: The parity flag is 1 when the result has an even number of ones.
- R8: For ADD and ADC, CY is the carry out of bit 7. For SUB, SBB and CMP, CY is set when a borrow occurs.
- R9: Code 8 INC and code 9 DEC return b+1 and b-1 modulo 256 with `opnd_wr_o` high and `acc_wr_o` low. They update S, Z, AC and P, and leave CY unchanged.
- R10: Code 10 DAD returns `hl_i`+`rp_i` modulo 65536 on `pair_o` with `pair_wr_o` high. CY is set to the carry out of bit 15, and S, Z, AC and P are unchanged. With `rp_i` equal to `hl_i`, the result is HL shifted left by one.
- R11: With `wr_en` low, or with codes 11 to 15, `result_o`, `pair_o` and all flags keep their values, and every write strobe is low in the next cycle.
- R12: Synchronous reset clears `result_o`, `pair_o`, every strobe and every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register the current operation |
| op_i | input | 4 | Operation code |
| src_i | input | 2 | Second-operand source select |
| acc_i | input | 8 | Accumulator value |
| imm_i | input | 8 | Immediate byte |
| reg_i | input | 8 | General register byte |
| mem_i | input | 8 | Memory byte addressed by a pair |
| hl_i | input | 16 | HL pair value |
| rp_i | input | 16 | Register pair added to HL |
| result_o | output | 8 | Registered 8-bit result |
| pair_o | output | 16 | Registered 16-bit sum |
| acc_wr_o | output | 1 | Write result to accumulator |
| opnd_wr_o | output | 1 | Write result to operand location |
| pair_wr_o | output | 1 | Write pair_o to HL |
| flag_s_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |
| flag_ac_o | output | 1 | Auxiliary carry flag |
| flag_p_o | output | 1 | Parity flag (even) |
| flag_cy_o | output | 1 | Carry / borrow flag |

## Verification
The carry flag written at one clock edge is consumed as the carry input of the very next ADC or SBB, in the same cycle that this flag is being rewritten. Back-to-back carry chains provoke this overlap, and so do INC and DEC placed between a carry-producing operation and a carry-consuming one. The bench judges each case against a reference model that tracks the flag state cycle by cycle. The same model covers DAD issued between 8-bit operations, where the carry changes but the other four flags must survive into the next 8-bit operation.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_DAD = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;
endpackage

// File: rtl/alu_opnd_mux.sv
module alu_opnd_mux #(
  parameter int DW = 8
) (
  input  logic [1:0]    src_i,
  input  logic [DW-1:0] imm_i,
  input  logic [DW-1:0] reg_i,
  input  logic [DW-1:0] mem_i,
  output logic [DW-1:0] opnd_o
);
  always_comb begin
    case (src_i)
      2'd0:    opnd_o = imm_i;
      2'd1:    opnd_o = reg_i;
      default: opnd_o = mem_i;
    endcase
  end
endmodule

// File: rtl/alu_core8.sv
module alu_core8
  import alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int HB = 4
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);
  logic [DW-1:0] x, y;
  logic          cin, borrow_mode, is_logic;
  logic [DW:0]   sum;

  // Adder operand steering: subtraction adds the one's complement of b.
  always_comb begin
    x           = a_i;
    y           = b_i;
    cin         = 1'b0;
    borrow_mode = 1'b0;
    case (op_i)
      OP_ADC: cin = cy_i;
      OP_SUB, OP_CMP: begin
        y = ~b_i; cin = 1'b1; borrow_mode = 1'b1;
      end
      OP_SBB: begin
        y = ~b_i; cin = ~cy_i; borrow_mode = 1'b1;
      end
      OP_INC: begin
        x = b_i; y = '0; cin = 1'b1;
      end
      OP_DEC: begin
        x = b_i; y = '1; cin = 1'b0;
      end
      default: ;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};

  assign is_logic = (op_i == OP_AND) || (op_i == OP_XOR) || (op_i == OP_OR);

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = sum[DW-1:0];
    endcase
    cy_o = is_logic ? 1'b0 : (sum[DW] ^ borrow_mode);
    // carry into bit HB recovered from the sum bit and both adder inputs
    ac_o = is_logic ? 1'b0 : (x[HB] ^ y[HB] ^ sum[HB]);
  end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] res_i,
  output logic          s_o,
  output logic          z_o,
  output logic          p_o
);
  assign s_o = res_i[DW-1];
  assign z_o = (res_i == '0);
  assign p_o = ~(^res_i);
endmodule

// File: rtl/alu_wide_add.sv
module alu_wide_add #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] a_i,
  input  logic [PW-1:0] b_i,
  output logic [PW-1:0] sum_o,
  output logic          cy_o
);
  assign {cy_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter  int DW = 8,
  parameter  int HB = 4,
  localparam int PW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [OPW-1:0] op_i,
  input  logic [1:0]     src_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  imm_i,
  input  logic [DW-1:0]  reg_i,
  input  logic [DW-1:0]  mem_i,
  input  logic [PW-1:0]  hl_i,
  input  logic [PW-1:0]  rp_i,
  output logic [DW-1:0]  result_o,
  output logic [PW-1:0]  pair_o,
  output logic           acc_wr_o,
  output logic           opnd_wr_o,
  output logic           pair_wr_o,
  output logic           flag_s_o,
  output logic           flag_z_o,
  output logic           flag_ac_o,
  output logic           flag_p_o,
  output logic           flag_cy_o
);
  alu_op_e       op;
  logic [DW-1:0] opnd, res8;
  logic          cy8, ac8, s8, z8, p8;
  logic [PW-1:0] wsum;
  logic          wcy;
  alu_flags_t    flags_q;

  assign op = alu_op_e'(op_i);

  alu_opnd_mux #(.DW(DW)) u_mux (
    .src_i(src_i), .imm_i(imm_i), .reg_i(reg_i), .mem_i(mem_i), .opnd_o(opnd)
  );

  alu_core8 #(.DW(DW), .HB(HB)) u_core (
    .op_i(op), .a_i(acc_i), .b_i(opnd), .cy_i(flags_q.cy),
    .res_o(res8), .cy_o(cy8), .ac_o(ac8)
  );

  alu_status #(.DW(DW)) u_stat (
    .res_i(res8), .s_o(s8), .z_o(z8), .p_o(p8)
  );

  alu_wide_add #(.PW(PW)) u_wide (
    .a_i(hl_i), .b_i(rp_i), .sum_o(wsum), .cy_o(wcy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      pair_o    <= '0;
      acc_wr_o  <= 1'b0;
      opnd_wr_o <= 1'b0;
      pair_wr_o <= 1'b0;
      flags_q   <= '0;
    end else begin
      acc_wr_o  <= 1'b0;
      opnd_wr_o <= 1'b0;
      pair_wr_o <= 1'b0;
      if (wr_en) begin
        case (op)
          OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_XOR, OP_OR: begin
            result_o <= res8;
            flags_q  <= '{s: s8, z: z8, ac: ac8, p: p8, cy: cy8};
            acc_wr_o <= 1'b1;
          end
          OP_CMP: begin
            result_o <= res8;
            flags_q  <= '{s: s8, z: z8, ac: ac8, p: p8, cy: cy8};
          end
          OP_INC, OP_DEC: begin
            result_o   <= res8;
            flags_q.s  <= s8;
            flags_q.z  <= z8;
            flags_q.ac <= ac8;
            flags_q.p  <= p8;
            opnd_wr_o  <= 1'b1;
          end
          OP_DAD: begin
            pair_o     <= wsum;
            flags_q.cy <= wcy;
            pair_wr_o  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign flag_s_o  = flags_q.s;
  assign flag_z_o  = flags_q.z;
  assign flag_ac_o = flags_q.ac;
  assign flag_p_o  = flags_q.p;
  assign flag_cy_o = flags_q.cy;

  logic is8, is_logic_op;
  assign is8 = wr_en && (op_i <= 4'd9);
  assign is_logic_op = wr_en && (op_i >= 4'd4) && (op_i <= 4'd6);

  p_logic_clear_r3: assert property (@(posedge clk) disable iff (rst)
    is_logic_op |=> (!flag_cy_o && !flag_ac_o && acc_wr_o));

  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_i == 4'd7) |=> (!acc_wr_o && !opnd_wr_o));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    is8 |=> (flag_z_o == (result_o == '0)) && (flag_s_o == result_o[DW-1]));

  p_even_parity_r7: assert property (@(posedge clk) disable iff (rst)
    is8 |=> (flag_p_o == ~(^result_o)));

  p_incdec_keep_cy_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (op_i == 4'd8 || op_i == 4'd9)) |=> ($stable(flag_cy_o) && opnd_wr_o && !acc_wr_o));

  p_dad_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_i == 4'd10) |=> ($stable({flag_s_o, flag_z_o, flag_ac_o, flag_p_o}) && pair_wr_o));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || op_i > 4'd10) |=> ($stable(result_o) && $stable(pair_o) && $stable(flags_q)
                                  && !acc_wr_o && !opnd_wr_o && !pair_wr_o));

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_wr_o, opnd_wr_o, pair_wr_o}));
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  src_i = '0;
  logic [7:0]  acc_i = '0, imm_i = '0, reg_i = '0, mem_i = '0;
  logic [15:0] hl_i = '0, rp_i = '0;
  logic [7:0]  result_o;
  logic [15:0] pair_o;
  logic        acc_wr_o, opnd_wr_o, pair_wr_o;
  logic        flag_s_o, flag_z_o, flag_ac_o, flag_p_o, flag_cy_o;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [7:0]  m_res = '0;
  logic [15:0] m_pair = '0;
  logic        m_aw = 0, m_ow = 0, m_pw = 0;
  logic        m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op_i(op_i), .src_i(src_i),
    .acc_i(acc_i), .imm_i(imm_i), .reg_i(reg_i), .mem_i(mem_i),
    .hl_i(hl_i), .rp_i(rp_i), .result_o(result_o), .pair_o(pair_o),
    .acc_wr_o(acc_wr_o), .opnd_wr_o(opnd_wr_o), .pair_wr_o(pair_wr_o),
    .flag_s_o(flag_s_o), .flag_z_o(flag_z_o), .flag_ac_o(flag_ac_o),
    .flag_p_o(flag_p_o), .flag_cy_o(flag_cy_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input logic [1:0] s, input logic [7:0] i,
                                      input logic [7:0] r, input logic [7:0] m);
    return (s == 2'd0) ? i : (s == 2'd1) ? r : m;
  endfunction

  task automatic set_szp(input logic [7:0] v);
    m_s = v[7];
    m_z = (v == 8'h00);
    m_p = ($countones(v) % 2) == 0;
  endtask

  // advance the reference by one registered operation
  task automatic model;
    logic [7:0] b, y;
    logic [8:0] f;
    logic       c;
    b = pick(src_i, imm_i, reg_i, mem_i);
    m_aw = 0; m_ow = 0; m_pw = 0;
    if (!wr_en) return;
    case (op_i)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd7: begin
        y = (op_i >= 4'd2) ? ~b : b;
        c = (op_i == 4'd0) ? 1'b0 : (op_i == 4'd1) ? m_cy : (op_i == 4'd3) ? ~m_cy : 1'b1;
        f = {1'b0, acc_i} + {1'b0, y} + {8'd0, c};
        m_ac = ({1'b0, acc_i[3:0]} + {1'b0, y[3:0]} + {4'd0, c}) > 5'd15;
        m_res = f[7:0];
        m_cy = (op_i >= 4'd2) ? ~f[8] : f[8];
        set_szp(m_res);
        m_aw = (op_i != 4'd7);
      end
      4'd4, 4'd5, 4'd6: begin
        m_res = (op_i == 4'd4) ? (acc_i & b) : (op_i == 4'd5) ? (acc_i ^ b) : (acc_i | b);
        m_cy = 0; m_ac = 0;
        set_szp(m_res);
        m_aw = 1;
      end
      4'd8: begin
        m_res = b + 8'd1;
        m_ac = (b[3:0] == 4'hF);
        set_szp(m_res);
        m_ow = 1;
      end
      4'd9: begin
        m_res = b - 8'd1;
        m_ac = (b[3:0] != 4'h0);
        set_szp(m_res);
        m_ow = 1;
      end
      4'd10: begin
        {m_cy, m_pair} = {1'b0, hl_i} + {1'b0, rp_i};
        m_pw = 1;
      end
      default: ;
    endcase
  endtask

  task automatic compare(input string req);
    check(result_o == m_res, req, "result", 32'(result_o), 32'(m_res));
    check(pair_o == m_pair, req, "pair", 32'(pair_o), 32'(m_pair));
    check({acc_wr_o, opnd_wr_o, pair_wr_o} == {m_aw, m_ow, m_pw}, req, "strobes",
          32'({acc_wr_o, opnd_wr_o, pair_wr_o}), 32'({m_aw, m_ow, m_pw}));
    check({flag_s_o, flag_z_o, flag_ac_o, flag_p_o, flag_cy_o} == {m_s, m_z, m_ac, m_p, m_cy},
          req, "flags SZAPC", 32'({flag_s_o, flag_z_o, flag_ac_o, flag_p_o, flag_cy_o}),
          32'({m_s, m_z, m_ac, m_p, m_cy}));
  endtask

  // called at a negative edge: drive, clock, compare at the next negative edge
  task automatic step(input string req, input bit w, input logic [3:0] op, input logic [1:0] src,
                      input logic [7:0] a, input logic [7:0] b);
    wr_en = w; op_i = op; src_i = src; acc_i = a;
    imm_i = (src == 2'd0) ? b : 8'h5A;
    reg_i = (src == 2'd1) ? b : 8'hA5;
    mem_i = (src[1]) ? b : 8'h3C;
    model();
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic dad(input string req, input logic [15:0] h, input logic [15:0] r);
    hl_i = h; rp_i = r;
    step(req, 1'b1, 4'd10, 2'd0, 8'h00, 8'h00);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check(result_o == 8'h00 && pair_o == 16'h0000, "R12", "reset data",
          32'({result_o, pair_o}), 32'd0);
    check({acc_wr_o, opnd_wr_o, pair_wr_o, flag_s_o, flag_z_o, flag_ac_o, flag_p_o, flag_cy_o} == '0,
          "R12", "reset flags", 32'({acc_wr_o, opnd_wr_o, pair_wr_o, flag_s_o, flag_z_o,
          flag_ac_o, flag_p_o, flag_cy_o}), 32'd0);

    // R1 source selection
    step("R1", 1, 4'd0, 2'd0, 8'h10, 8'h01);
    step("R1", 1, 4'd0, 2'd1, 8'h10, 8'h02);
    step("R1", 1, 4'd0, 2'd2, 8'h10, 8'h03);
    step("R1", 1, 4'd0, 2'd3, 8'h10, 8'h04);
    // R5 half carry, R8 carry out, R6 zero
    step("R5", 1, 4'd0, 2'd0, 8'h0F, 8'h01);
    check(result_o == 8'h10 && flag_ac_o, "R5", "0F+01", 32'({result_o, flag_ac_o}), 32'h21);
    step("R8", 1, 4'd0, 2'd0, 8'hFF, 8'h01);
    check(flag_cy_o && flag_z_o, "R8", "FF+01 CY,Z", 32'({flag_cy_o, flag_z_o}), 32'h3);
    // R2 carry chain: ADC consumes the carry just written
    step("R2", 1, 4'd1, 2'd1, 8'h00, 8'h00);
    check(result_o == 8'h01, "R2", "ADC carry-in", 32'(result_o), 32'h01);
    step("R8", 1, 4'd2, 2'd0, 8'h00, 8'h01);
    check(result_o == 8'hFF && flag_cy_o && flag_s_o, "R8", "borrow", 32'({result_o, flag_cy_o}),
          32'h1FF);
    step("R2", 1, 4'd3, 2'd0, 8'h05, 8'h01);
    check(result_o == 8'h03, "R2", "SBB borrow-in", 32'(result_o), 32'h03);
    // R7 parity
    step("R7", 1, 4'd6, 2'd0, 8'h01, 8'h02);
    check(flag_p_o == 1'b1, "R7", "even parity 03", 32'(flag_p_o), 32'd1);
    step("R7", 1, 4'd5, 2'd0, 8'h07, 8'h00);
    check(flag_p_o == 1'b0, "R7", "odd parity 07", 32'(flag_p_o), 32'd0);
    // R3 logic clears carry
    step("R8", 1, 4'd0, 2'd0, 8'h80, 8'h80);
    step("R3", 1, 4'd4, 2'd0, 8'hF0, 8'h3C);
    check(!flag_cy_o && result_o == 8'h30, "R3", "AND", 32'({flag_cy_o, result_o}), 32'h30);
    // R4 compare
    step("R4", 1, 4'd7, 2'd2, 8'h42, 8'h42);
    check(flag_z_o && !acc_wr_o, "R4", "CMP equal", 32'({flag_z_o, acc_wr_o}), 32'h2);
    // R9 increment / decrement keep carry
    step("R8", 1, 4'd0, 2'd0, 8'hFF, 8'hFF);
    step("R9", 1, 4'd8, 2'd1, 8'h00, 8'hFF);
    check(result_o == 8'h00 && flag_cy_o && flag_ac_o && opnd_wr_o, "R9", "INC FF",
          32'({result_o, flag_cy_o, flag_ac_o, opnd_wr_o}), 32'h7);
    step("R9", 1, 4'd9, 2'd2, 8'h00, 8'h00);
    check(result_o == 8'hFF && flag_cy_o && !flag_ac_o, "R9", "DEC 00",
          32'({result_o, flag_cy_o, flag_ac_o}), 32'h3FE);
    // R10 16-bit add, HL doubled
    dad("R10", 16'h8001, 16'h8001);
    check(pair_o == 16'h0002 && flag_cy_o && flag_s_o, "R10", "DAD HL+HL",
          32'({pair_o, flag_cy_o}), 32'h00005);
    dad("R10", 16'h1234, 16'h0F0F);
    // R11 hold
    step("R11", 0, 4'd0, 2'd0, 8'h11, 8'h22);
    step("R11", 1, 4'd12, 2'd0, 8'h11, 8'h22);
    step("R11", 1, 4'd15, 2'd1, 8'h00, 8'h00);

    // constrained random mix, carry chains included
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic       w;
      w  = ($urandom % 8) != 0;
      op = 4'($urandom % 13);
      hl_i = 16'($urandom);
      rp_i = (($urandom % 4) == 0) ? hl_i : 16'($urandom);
      step("R2/R9/R10/R11 random", w, op, 2'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule